// File: doc/BRIEF.md
# Signed-Digit Redundant Adder

This block adds two N-digit radix-2 numbers whose digits each take one of three values, minus one, zero or plus one. Because the digit set is redundant, one value can be written more than one way: plus one is both "0 1" and "1 -1". The adder uses that freedom to avoid a carry chain. Each digit position forms the sum of its two input digits. It then splits that sum into a transfer digit, sent to the next higher position, and an interim digit, kept locally. The split depends only on whether either input digit one position lower is negative.

The final digit at each position is its interim digit plus the transfer arriving from below. That addition never leaves the digit set, so the logic depth is the same for every word length. The result has N+1 digits, and the top digit is the transfer out of the highest position.

Both operands and the result use a 2-bit code per digit. The result and an error flag are registered once, so they appear one clock after the operands. Any operand digit carrying the unused code forces the error flag and a zero result.

Top module: `sbd_adder`

## Requirements
- R1: Digit i of every bus occupies bits [2i+1:2i]. Code 2'b00 is zero, 2'b01 is plus one, 2'b10 is minus one, and 2'b11 is illegal. The sum bus carries N+1 digits.
- R2: When all operand digits are legal, the numeric value of sum one clock later equals the value of a plus the value of b. The value is the sum of digit × 2^i.
- R3: When err is low, no digit of sum carries the illegal code 2'b11.
- R4: When any digit of a or b carries code 2'b11, err is high on the next clock and every bit of sum is zero. When all digits are legal, err is low on the next clock.
- R5: A position whose pair sum is +1 or -1 chooses its split from the digits one position lower. If a lower digit is negative, +1 becomes transfer 0 and interim +1, and -1 becomes transfer -1 and interim +1. Otherwise +1 becomes transfer +1 and interim -1, and -1 becomes transfer 0 and interim -1. Position 0 always takes the "no negative" choice.
- R6: Pair sum +2 gives transfer +1, pair sum -2 gives transfer -1, and pair sum 0 gives transfer 0, each with interim 0. The top sum digit is the transfer out of position N-1.
- R7: While rst_n is low, sum is zero and err is low, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 2*N | First operand, one 2-bit code per digit |
| b | input | 2*N | Second operand, one 2-bit code per digit |
| sum | output | 2*N+2 | Registered result, N+1 digits |
| err | output | 1 | Registered flag: an operand digit was illegal |

## Verification
The bench builds two copies of the block. The first has N=4, small enough to feed every legal operand pair (81 × 81) and compare values exhaustively. It also takes hand-worked vectors whose exact digit pattern in the result is predicted from the transfer rules, including the lower-negative choice and a negative top digit. The second copy has N=8 and runs random operand pairs, so the transfer chain is exercised across a wider word than the exhaustive set covers.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  typedef logic [1:0] sbd_code_t;

  localparam sbd_code_t SBD_ZERO = 2'b00;
  localparam sbd_code_t SBD_POS  = 2'b01;
  localparam sbd_code_t SBD_NEG  = 2'b10;
  localparam sbd_code_t SBD_BAD  = 2'b11;

  typedef struct packed {
    sbd_code_t xfer;
    sbd_code_t interim;
  } sbd_split_t;

  // numeric value of one digit code (illegal code reads as zero)
  function automatic logic signed [2:0] sbd_value(sbd_code_t c);
    case (c)
      SBD_POS: sbd_value = 3'sd1;
      SBD_NEG: sbd_value = -3'sd1;
      default: sbd_value = 3'sd0;
    endcase
  endfunction

  function automatic sbd_code_t sbd_encode(logic signed [2:0] v);
    if (v == 3'sd1)       sbd_encode = SBD_POS;
    else if (v == -3'sd1) sbd_encode = SBD_NEG;
    else                  sbd_encode = SBD_ZERO;
  endfunction

  function automatic logic sbd_is_neg(sbd_code_t c);
    sbd_is_neg = (c == SBD_NEG);
  endfunction

  // split a pair sum into transfer and interim, steered by the lower position
  function automatic sbd_split_t sbd_split(logic signed [2:0] pair, logic lower_neg);
    sbd_split_t r;
    r.xfer    = SBD_ZERO;
    r.interim = SBD_ZERO;
    if (pair == 3'sd2) begin
      r.xfer = SBD_POS;
    end else if (pair == -3'sd2) begin
      r.xfer = SBD_NEG;
    end else if (pair == 3'sd1) begin
      r.xfer    = lower_neg ? SBD_ZERO : SBD_POS;
      r.interim = lower_neg ? SBD_POS  : SBD_NEG;
    end else if (pair == -3'sd1) begin
      r.xfer    = lower_neg ? SBD_NEG : SBD_ZERO;
      r.interim = lower_neg ? SBD_POS : SBD_NEG;
    end
    sbd_split = r;
  endfunction

endpackage

// File: rtl/sbd_digit_split.sv
module sbd_digit_split
  import sbd_pkg::*;
(
  input  logic [1:0] a_d,
  input  logic [1:0] b_d,
  input  logic       lower_neg,
  output logic [1:0] xfer,
  output logic [1:0] interim,
  output logic       bad_here
);

  logic signed [2:0] pair;
  sbd_split_t        parts;

  always_comb begin
    pair     = sbd_value(a_d) + sbd_value(b_d);
    parts    = sbd_split(pair, lower_neg);
    xfer     = parts.xfer;
    interim  = parts.interim;
    bad_here = (a_d == SBD_BAD) || (b_d == SBD_BAD);
  end

endmodule

// File: rtl/sbd_digit_merge.sv
module sbd_digit_merge
  import sbd_pkg::*;
(
  input  logic [1:0] interim,
  input  logic [1:0] xfer_in,
  output logic [1:0] sum_d
);

  logic signed [2:0] total;

  always_comb begin
    total = sbd_value(interim) + sbd_value(xfer_in);
    sum_d = sbd_encode(total);
  end

endmodule

// File: rtl/sbd_adder.sv
module sbd_adder
  import sbd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*N-1:0]   a,
  input  logic [2*N-1:0]   b,
  output logic [2*N+1:0]   sum,
  output logic             err
);

  localparam int OW = 2*N + 2;

  logic [1:0]    xfer    [N];
  logic [1:0]    interim [N];
  logic [1:0]    final_d [N];
  logic [N-1:0]  low_neg;
  logic [N-1:0]  bad_pos;
  logic          any_bad;
  logic [OW-1:0] comb_sum;
  logic [OW-1:0] sum_q;
  logic          err_q;

  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i == 0) begin : g_base
      assign low_neg[i] = 1'b0;
    end else begin : g_upper
      assign low_neg[i] = sbd_is_neg(a[2*(i-1) +: 2]) | sbd_is_neg(b[2*(i-1) +: 2]);
    end

    sbd_digit_split u_split (
      .a_d       (a[2*i +: 2]),
      .b_d       (b[2*i +: 2]),
      .lower_neg (low_neg[i]),
      .xfer      (xfer[i]),
      .interim   (interim[i]),
      .bad_here  (bad_pos[i])
    );

    if (i == 0) begin : g_m0
      sbd_digit_merge u_merge (
        .interim (interim[i]),
        .xfer_in (SBD_ZERO),
        .sum_d   (final_d[i])
      );
    end else begin : g_mi
      sbd_digit_merge u_merge (
        .interim (interim[i]),
        .xfer_in (xfer[i-1]),
        .sum_d   (final_d[i])
      );
    end

    assign comb_sum[2*i +: 2] = final_d[i];
  end

  assign comb_sum[2*N +: 2] = xfer[N-1];
  assign any_bad            = |bad_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      err_q <= 1'b0;
    end else begin
      sum_q <= any_bad ? '0 : comb_sum;
      err_q <= any_bad;
    end
  end

  assign sum = sum_q;
  assign err = err_q;

endmodule

// File: rtl/sbd_adder_chk.sv
module sbd_adder_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*N-1:0] a,
  input logic [2*N-1:0] b,
  input logic [2*N+1:0] sum,
  input logic           err
);

  function automatic int dval(logic [1:0] c);
    return (c == 2'b01) ? 1 : ((c == 2'b10) ? -1 : 0);
  endfunction

  function automatic int op_val(logic [2*N-1:0] v);
    int acc = 0;
    for (int k = N - 1; k >= 0; k--) acc = acc * 2 + dval(v[2*k +: 2]);
    return acc;
  endfunction

  function automatic int res_val(logic [2*N+1:0] v);
    int acc = 0;
    for (int k = N; k >= 0; k--) acc = acc * 2 + dval(v[2*k +: 2]);
    return acc;
  endfunction

  function automatic logic op_has_bad(logic [2*N-1:0] v);
    logic f = 1'b0;
    for (int k = 0; k < N; k++) f = f | (v[2*k +: 2] == 2'b11);
    return f;
  endfunction

  function automatic logic res_has_bad(logic [2*N+1:0] v);
    logic f = 1'b0;
    for (int k = 0; k <= N; k++) f = f | (v[2*k +: 2] == 2'b11);
    return f;
  endfunction

  logic in_bad;
  int   in_total;
  int   out_total;

  always_comb begin
    in_bad    = op_has_bad(a) | op_has_bad(b);
    in_total  = op_val(a) + op_val(b);
    out_total = res_val(sum);
  end

  // R2
  value_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_bad |=> out_total == $past(in_total));

  // R3
  legal_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> !res_has_bad(sum));

  // R4
  bad_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_bad |=> (err && sum == '0));

  // R4
  clean_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_bad |=> !err);

endmodule

bind sbd_adder sbd_adder_chk #(.N(N)) u_sbd_adder_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .a     (a),
  .b     (b),
  .sum   (sum),
  .err   (err)
);

// File: tb/sbd_adder_bench.sv
module sbd_adder_bench;

  localparam int NN = 4;
  localparam int NW = 8;

  typedef struct packed {
    logic               bad;
    logic               exact;
    logic signed [31:0] val;
    logic [63:0]        rep;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*NN-1:0] a_n = '0, b_n = '0;
  logic [2*NW-1:0] a_w = '0, b_w = '0;
  logic [2*NN+1:0] sum_n;
  logic [2*NW+1:0] sum_w;
  logic err_n, err_w;

  int checks = 0;
  int errors = 0;

  exp_t  q_n[$];
  exp_t  q_w[$];
  string t_n[$];
  string t_w[$];

  always #2 clk = ~clk;

  sbd_adder #(.N(NN)) u_sbd_adder (
    .clk(clk), .rst_n(rst_n), .a(a_n), .b(b_n), .sum(sum_n), .err(err_n));

  sbd_adder #(.N(NW)) u_sbd_adder_wide (
    .clk(clk), .rst_n(rst_n), .a(a_w), .b(b_w), .sum(sum_w), .err(err_w));

  function automatic int code_val(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return -1;
    return 0;
  endfunction

  function automatic int vec_val(logic [63:0] v, int nd);
    int acc = 0;
    int w = 1;
    for (int k = 0; k < nd; k++) begin
      acc += w * code_val(v[2*k +: 2]);
      w *= 2;
    end
    return acc;
  endfunction

  function automatic bit vec_bad(logic [63:0] v, int nd);
    bit f = 0;
    for (int k = 0; k < nd; k++) if (v[2*k +: 2] == 2'b11) f = 1;
    return f;
  endfunction

  function automatic logic [63:0] tern_pattern(int idx, int nd);
    logic [63:0] r = '0;
    int x = idx;
    for (int k = 0; k < nd; k++) begin
      r[2*k +: 2] = (x % 3 == 1) ? 2'b01 : ((x % 3 == 2) ? 2'b10 : 2'b00);
      x = x / 3;
    end
    return r;
  endfunction

  function automatic exp_t make_exp(logic [63:0] a, logic [63:0] b, int nd,
                                    bit exact, logic [63:0] rep);
    exp_t e;
    e.bad   = vec_bad(a, nd) | vec_bad(b, nd);
    e.exact = exact;
    e.val   = vec_val(a, nd) + vec_val(b, nd);
    e.rep   = rep;
    return e;
  endfunction

  task automatic drive_n(logic [2*NN-1:0] a, logic [2*NN-1:0] b, string tag,
                         bit exact, logic [63:0] rep);
    @(negedge clk);
    a_n = a;
    b_n = b;
    q_n.push_back(make_exp(64'(a), 64'(b), NN, exact, rep));
    t_n.push_back(tag);
  endtask

  task automatic drive_w(logic [2*NW-1:0] a, logic [2*NW-1:0] b, string tag);
    @(negedge clk);
    a_w = a;
    b_w = b;
    q_w.push_back(make_exp(64'(a), 64'(b), NW, 1'b0, 64'd0));
    t_w.push_back(tag);
  endtask

  task automatic judge(exp_t e, string tag, logic [63:0] s, logic eflag, int nd);
    checks++;
    if (e.bad) begin
      if (eflag !== 1'b1 || s !== 64'd0) begin
        errors++;
        $display("FAIL %s: err=%0b sum=%h expected err=1 sum=0", tag, eflag, s);
      end
    end else begin
      if (eflag !== 1'b0 || vec_val(s, nd + 1) != e.val || vec_bad(s, nd + 1)) begin
        errors++;
        $display("FAIL %s: err=%0b value=%0d expected err=0 value=%0d (digits %h)",
                 tag, eflag, vec_val(s, nd + 1), e.val, s);
      end
      if (e.exact) begin
        checks++;
        if (s !== e.rep) begin
          errors++;
          $display("FAIL %s: digits %h expected %h", tag, s, e.rep);
        end
      end
    end
  endtask

  // monitor: results appear one clock after the driving negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_n.size() > 0) judge(q_n.pop_front(), t_n.pop_front(), 64'(sum_n), err_n, NN);
      if (q_w.size() > 0) judge(q_w.pop_front(), t_w.pop_front(), 64'(sum_w), err_w, NW);
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset holds outputs at zero even with live operands
    a_n = 8'h05;
    b_n = 8'h14;
    a_w = 16'h0101;
    b_w = 16'h1010;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (sum_n !== '0 || err_n !== 1'b0 || sum_w !== '0 || err_w !== 1'b0) begin
      errors++;
      $display("FAIL R7: sum=%h err=%0b expected sum=0 err=0", sum_n, err_n);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R5: lower-negative steering, exact digit patterns
    drive_n(8'h01, 8'h00, "R5 +1 no lower neg", 1'b1, 64'h006);
    drive_n(8'h04, 8'h02, "R5 +1 with lower neg", 1'b1, 64'h006);
    drive_n(8'h08, 8'h02, "R5 -1 with lower neg", 1'b1, 64'h026);
    drive_n(8'h02, 8'h00, "R5 -1 at position 0", 1'b1, 64'h002);
    // R6: pair sums of +2 / -2 and the top digit
    drive_n(8'h04, 8'h04, "R6 pair +2", 1'b1, 64'h010);
    drive_n(8'h80, 8'h80, "R6 top digit -1", 1'b1, 64'h200);
    drive_n(8'h40, 8'h40, "R6 top digit +1", 1'b1, 64'h100);
    // R4: illegal code in either operand, then recovery
    drive_n(8'h03, 8'h00, "R4 illegal a digit0", 1'b0, 64'd0);
    drive_n(8'h00, 8'hC0, "R4 illegal b digit3", 1'b0, 64'd0);
    drive_n(8'h00, 8'h00, "R4 recovery", 1'b1, 64'h000);

    // R1 R2 R3: every legal operand pair at N=4
    for (int i = 0; i < 81; i++)
      for (int j = 0; j < 81; j++)
        drive_n(tern_pattern(i, NN)[2*NN-1:0], tern_pattern(j, NN)[2*NN-1:0],
                "R2 exhaustive", 1'b0, 64'd0);

    // R2 R3: random pairs on the wide instance
    for (int r = 0; r < 2000; r++)
      drive_w(tern_pattern(int'($urandom % 6561), NW)[2*NW-1:0],
              tern_pattern(int'($urandom % 6561), NW)[2*NW-1:0], "R2 random wide");
    drive_w(16'h0003, 16'h0000, "R4 wide illegal");
    drive_w(16'h5555, 16'h5555, "R6 wide all +1");
    drive_w(16'hAAAA, 16'hAAAA, "R6 wide all -1");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule